// File: doc/BRIEF.md
# Shared-Address Two-Read RAM

This block is a synchronous word memory with one write port and two read ports, arranged so that it needs only two physical address ports and can therefore be mapped onto a single true dual-port RAM. The first physical port is shared. While the write enable is high it carries the write address and stores the write data. While the write enable is low it carries the first read address and feeds the first read output. The second physical port only ever reads, at the second read address.

Both read results come out of registers. Because the shared port cannot read and write in the same cycle, the block performs no reads at all on a write cycle, and both outputs keep the values they already had. An active-low synchronous reset clears both outputs to zero and leaves the stored words untouched. The data width and the address width are parameters, and the depth is two to the power of the address width.

Top module: `twin_read_ram`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_data` is stored at `wr_addr`.
- R2: After a rising edge at which `wr_en` is low and `rst_n` is high, `rd_data0` shows the word stored at `rd_addr0` as sampled at that edge.
- R3: After the same kind of edge, `rd_data1` shows the word stored at `rd_addr1`, whatever values `rd_addr0` and `wr_addr` have.
- R4: After a rising edge at which `wr_en` is high and `rst_n` is high, both read outputs keep their previous values.
- R5: After a rising edge at which `rst_n` is low, both read outputs are zero, whatever `wr_en` is.
- R6: Reset does not clear the stored words. A word written before reset reads back unchanged after reset is released.
- R7: When both read addresses are equal on a read cycle, both outputs show the same word after the edge.
- R8: A read on the cycle right after a write to the same address returns the newly written data.
- R9: `DATA_W` and `ADDR_W` are parameters, and every one of the 2^`ADDR_W` addresses, including address 0 and the top address, holds its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, clears both read outputs |
| wr_en | input | 1 | Write enable. High means a write cycle on the shared port |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Word to store |
| rd_addr0 | input | ADDR_W | First read address, served by the shared port |
| rd_addr1 | input | ADDR_W | Second read address, served by the read-only port |
| rd_data0 | output | DATA_W | Registered word read at rd_addr0 |
| rd_data1 | output | DATA_W | Registered word read at rd_addr1 |

## Verification
The hardest case to reach is a write cycle that must leave both outputs frozen while the read addresses point at words different from the ones on display. A frozen output can only be told apart from a fresh read if the addressed word differs from the one shown. The stimulus therefore writes distinct values first. It then issues writes while the read addresses sit on other loaded locations, and follows them with a read of the just-written address to show that the held value was not a delayed read. Reset is raised in the middle of a run on a read cycle, and a later read proves that the stored words survived it.

// File: rtl/twin_read_ram_pkg.sv
package twin_read_ram_pkg;

   // number of physical ports in the underlying dual-port array
   localparam int unsigned PORTS = 2;

   // role of each physical port
   typedef enum logic {
      PORT_SHARED   = 1'b0,
      PORT_READONLY = 1'b1
   } port_role_e;

   // largest address width accepted by the elaboration checks
   localparam int unsigned MAX_ADDR_W = 16;

endpackage

// File: rtl/trr_addr_steer.sv
module trr_addr_steer
   import twin_read_ram_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [ADDR_W-1:0]                rd_addr0,
   input  logic [ADDR_W-1:0]                rd_addr1,
   output logic [PORTS-1:0][ADDR_W-1:0]     port_addr,
   output logic [PORTS-1:0]                 port_rd_en,
   output logic                             port_we
);

   // the shared port takes the write address on write cycles
   always_comb begin
      port_addr[PORT_SHARED] = wr_en ? wr_addr : rd_addr0;
      port_addr[PORT_READONLY] = rd_addr1;
   end

   // no port reads on a write cycle, so the outputs keep their values
   for (genvar p = 0; p < PORTS; p++) begin : g_rd_en
      assign port_rd_en[p] = ~wr_en;
   end

   assign port_we = wr_en;

endmodule

// File: rtl/trr_tdp_core.sv
module trr_tdp_core
   import twin_read_ram_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             port_we,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [PORTS-1:0][ADDR_W-1:0]     port_addr,
   input  logic [PORTS-1:0]                 port_rd_en,
   output logic [PORTS-1:0][DATA_W-1:0]     rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // the write goes through the shared port only, and reset never touches it
   always_ff @(posedge clk) begin
      if (port_we) store[port_addr[PORT_SHARED]] <= wr_data;
   end

   // one registered read per physical port
   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (!rst_n)            rdata[p] <= '0;
         else if (port_rd_en[p]) rdata[p] <= store[port_addr[p]];
      end
   end

   logic chk_armed = 1'b0;
   always_ff @(posedge clk) chk_armed <= 1'b1;

   // R5
   rst_clear_chk: assert property (@(posedge clk)
      (chk_armed && $past(!rst_n)) |-> (rdata == '0));

   // R4
   hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && $past(port_we) && $past(rst_n)) |-> $stable(rdata));

endmodule

// File: rtl/twin_read_ram.sv
module twin_read_ram
   import twin_read_ram_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr0,
   input  logic [ADDR_W-1:0] rd_addr1,
   output logic [DATA_W-1:0] rd_data0,
   output logic [DATA_W-1:0] rd_data1
);

   // R9 elaboration checks on the parameters
   if (DATA_W < 1) begin : g_bad_data_w
      $error("twin_read_ram: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("twin_read_ram: ADDR_W out of range");
   end

   logic [PORTS-1:0][ADDR_W-1:0] port_addr;
   logic [PORTS-1:0]             port_rd_en;
   logic                         port_we;
   logic [PORTS-1:0][DATA_W-1:0] rdata;

   trr_addr_steer #(.ADDR_W(ADDR_W)) u_steer (
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .rd_addr0   (rd_addr0),
      .rd_addr1   (rd_addr1),
      .port_addr  (port_addr),
      .port_rd_en (port_rd_en),
      .port_we    (port_we)
   );

   trr_tdp_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_we    (port_we),
      .wr_data    (wr_data),
      .port_addr  (port_addr),
      .port_rd_en (port_rd_en),
      .rdata      (rdata)
   );

   assign rd_data0 = rdata[PORT_SHARED];
   assign rd_data1 = rdata[PORT_READONLY];

   // R7
   same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (rd_addr0 == rd_addr1)) |=> (rd_data0 == rd_data1));

   // R8
   fresh_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en ##1 (!wr_en && rst_n && (rd_addr0 == $past(wr_addr))))
      |=> (rd_data0 == $past(wr_data, 2)));

endmodule

// File: tb/twin_read_ram_test.sv
module twin_read_ram_test;

   localparam int unsigned DW = 16;
   localparam int unsigned AW = 4;
   localparam int unsigned VW = 1 + AW + DW + AW + AW + DW + DW;
   localparam int unsigned NVEC = 10;

   // {wr_en, wr_addr, wr_data, rd_addr0, rd_addr1, expect0, expect1}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b1, 4'h3, 16'h1111, 4'h0, 4'h0, 16'h0000, 16'h0000},  // R1 R4
      {1'b1, 4'h5, 16'h2222, 4'h3, 4'h5, 16'h0000, 16'h0000},  // R4
      {1'b0, 4'h0, 16'h0000, 4'h3, 4'h5, 16'h1111, 16'h2222},  // R2 R3
      {1'b1, 4'h3, 16'h3333, 4'h5, 4'h5, 16'h1111, 16'h2222},  // R4
      {1'b0, 4'h9, 16'hDEAD, 4'h3, 4'h3, 16'h3333, 16'h3333},  // R7 R8
      {1'b1, 4'h0, 16'hA5A5, 4'h5, 4'h3, 16'h3333, 16'h3333},  // R4 R9
      {1'b1, 4'hF, 16'hFFFF, 4'h0, 4'hF, 16'h3333, 16'h3333},  // R4 R9
      {1'b0, 4'h3, 16'h0BAD, 4'hF, 4'h0, 16'hFFFF, 16'hA5A5},  // R9
      {1'b0, 4'h5, 16'h0BAD, 4'h0, 4'hF, 16'hA5A5, 16'hFFFF},  // R3
      {1'b0, 4'h0, 16'h0000, 4'h5, 4'h3, 16'h2222, 16'h3333}   // R2 R3
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr0 = '0;
   logic [AW-1:0] rd_addr1 = '0;
   logic [DW-1:0] rd_data0;
   logic [DW-1:0] rd_data1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   twin_read_ram #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
      .rd_data0(rd_data0), .rd_data1(rd_data1)
   );

   task automatic check(input string req, input logic [DW-1:0] e0, input logic [DW-1:0] e1);
      checks++;
      if (rd_data0 !== e0 || rd_data1 !== e1) begin
         errors++;
         $display("FAIL %s: got %h/%h expected %h/%h", req, rd_data0, rd_data1, e0, e1);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, sample at the next falling edge
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] a0, input logic [AW-1:0] a1);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr0 = a0; rd_addr1 = a1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R5 reset state", 16'h0000, 16'h0000);
      rst_n = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         step(v[VW-1], v[VW-2 -: AW], v[VW-2-AW -: DW], v[2*DW+2*AW-1 -: AW],
              v[2*DW+AW-1 -: AW]);
         check($sformatf("R1-table vec %0d", i), v[2*DW-1 -: DW], v[DW-1:0]);
      end
      // R5: reset on a read cycle clears the outputs
      rst_n = 1'b0;
      step(1'b0, 4'h0, 16'h0, 4'h3, 4'hF);
      check("R5 reset mid-run", 16'h0000, 16'h0000);
      // R5: reset wins over a write cycle as well
      step(1'b1, 4'h9, 16'h7777, 4'h3, 4'hF);
      check("R5 reset with write", 16'h0000, 16'h0000);
      rst_n = 1'b1;
      // R6: stored words survive reset
      step(1'b0, 4'h0, 16'h0, 4'h3, 4'hF);
      check("R6 contents kept", 16'h3333, 16'hFFFF);
      // R4: a write cycle while both read addresses point at other loaded words
      step(1'b1, 4'h5, 16'h4444, 4'h0, 4'h5);
      check("R4 hold on write", 16'h3333, 16'hFFFF);
      // R8: read right after the write, from both lanes
      step(1'b0, 4'h0, 16'h0, 4'h5, 4'h5);
      check("R8 fresh data", 16'h4444, 16'h4444);
      // R3: read-only lane ignores rd_addr0 and wr_addr
      step(1'b0, 4'hF, 16'h1234, 4'h0, 4'h3);
      check("R3 independent lane", 16'hA5A5, 16'h3333);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule